// File: doc/BRIEF.md
# Banked Lane Scratchpad with Conflict Serialization

This block is a word-interleaved on-chip scratchpad that takes one request from a group of 16 parallel lanes at a time. Each lane may carry a read or a write to a 32-bit word. The words are spread across 16 single-ported banks. Lanes that land in different banks are all served in the same clock. When several lanes want different words in one bank, the request is spread over as many clocks as the busiest bank needs. Lanes that name exactly the same word share one bank access, and a read is broadcast to all of them.

In each serving clock, every bank takes the address of its lowest-numbered lane that is still waiting. It then completes every waiting lane that carries that same address. A request is taken with a valid/ready handshake. While the request is being served, ready stays low. A one-clock done pulse marks the end of the request, and from then on every lane's read data is held.

Top module: `lane_bank_mem`

## Requirements
- R1: A word address selects bank `addr[3:0]` (address mod 16) and row `addr[9:4]`. Consecutive words therefore sit in different banks, and a request whose valid lanes all fall in distinct banks completes in one serving clock.
- R2: `req_ready` is 1 when idle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from the edge after acceptance until the cycle in which `done` is 1. `done` is 1 for exactly one cycle, k clock edges after the acceptance edge. A request with no valid lane takes k = 1.
- R3: k equals the largest number of distinct word addresses among valid lanes that share one bank, and is at least 1. A stride-1 or stride-3 access over 16 lanes gives k = 1, stride 2 gives k = 2, stride 8 gives k = 8, and stride 16 gives k = 16.
- R4: Valid read lanes that name one identical address all receive that word, at the cost of a single bank access.
- R5: A valid read lane (`lane_we` bit 0) returns, on `rd_data` lane slice `[32*l +: 32]`, the word stored before the request. This holds even when another lane of the same request writes that address.
- R6: A valid write lane (`lane_we` bit 1) stores its data. When several lanes write one address, the highest-numbered lane's data is kept.
- R7: A lane whose `lane_valid` bit is 0 neither writes memory nor changes its `rd_data` slice. A write lane's `rd_data` slice also keeps its previous value.
- R8: `rd_data` does not change from the `done` cycle until the next accepted request is served.
- R9: After reset, `req_ready` is 1, `done` is 0 and `rd_data` is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | A lane request is offered |
| req_ready | output | 1 | Block is idle and accepts a request |
| lane_valid | input | 16 | Per-lane participation mask |
| lane_we | input | 16 | Per-lane write select (1 = write, 0 = read) |
| lane_addr | input | 160 | Per-lane 10-bit word address, lane l at `[10*l +: 10]` |
| lane_wdata | input | 512 | Per-lane write word, lane l at `[32*l +: 32]` |
| rd_data | output | 512 | Per-lane read word, lane l at `[32*l +: 32]` |
| done | output | 1 | One-cycle pulse when all lanes of the request are served |

## Verification
The bench measures latency on even, odd, 8- and 16-word strides. A design that counted lanes per bank instead of distinct words would be slow on broadcast reads. A design that ignored the bank field would report a stride-16 access as conflict-free.

Other cases target the data path:
- Many lanes writing one word exposes a wrong winner.
- A read and a write to one word in the same request catches a write that leaks into the read.
- Lanes that are invalid but have write enable set would corrupt memory in a design that ignored the valid mask.

A long constrained-random run over a small address pool mixes all of these cases.

// File: rtl/spm_pkg.sv
package spm_pkg;

  typedef enum logic {
    ST_IDLE  = 1'b0,
    ST_SERVE = 1'b1
  } spm_state_e;

  // Bank index of a word address for a power-of-two bank count.
  function automatic int unsigned bank_of(input logic [31:0] waddr,
                                          input int unsigned nbanks);
    return waddr % nbanks;
  endfunction

  // Row inside the bank for a word address.
  function automatic int unsigned row_of(input logic [31:0] waddr,
                                         input int unsigned nbanks);
    return waddr / nbanks;
  endfunction

endpackage

// File: rtl/spm_bank_pick.sv
// Per-bank selector: finds the lowest waiting lane in this bank, groups all
// waiting lanes with the same address, and merges their writes.
module spm_bank_pick #(
  parameter int unsigned LANES   = 16,
  parameter int unsigned BANKS   = 16,
  parameter int unsigned ADDR_W  = 10,
  parameter int unsigned WORD_W  = 32,
  parameter int unsigned BANK_ID = 0,
  localparam int unsigned BANK_W = $clog2(BANKS),
  localparam int unsigned ROW_W  = ADDR_W - BANK_W
) (
  input  logic [LANES-1:0]        pending,
  input  logic [LANES*ADDR_W-1:0] addr_vec,
  input  logic [LANES-1:0]        we_vec,
  input  logic [LANES*WORD_W-1:0] wdata_vec,
  output logic [LANES-1:0]        serve,
  output logic [ROW_W-1:0]        row,
  output logic                    wr_en,
  output logic [WORD_W-1:0]       wr_word
);

  logic [LANES-1:0]  hit;
  logic [ADDR_W-1:0] lead_addr;
  logic              found;

  always_comb begin
    hit = '0;
    for (int l = 0; l < LANES; l++) begin
      hit[l] = pending[l] &&
               (spm_pkg::bank_of(32'(addr_vec[l*ADDR_W +: ADDR_W]), BANKS) == BANK_ID);
    end
  end

  // Lowest-numbered waiting lane sets this cycle's address.
  always_comb begin
    lead_addr = '0;
    found     = 1'b0;
    for (int l = 0; l < LANES; l++) begin
      if (hit[l] && !found) begin
        lead_addr = addr_vec[l*ADDR_W +: ADDR_W];
        found     = 1'b1;
      end
    end
  end

  always_comb begin
    serve = '0;
    for (int l = 0; l < LANES; l++) begin
      serve[l] = hit[l] && (addr_vec[l*ADDR_W +: ADDR_W] == lead_addr);
    end
  end

  // Ascending scan: the last match, i.e. the highest lane, wins.
  always_comb begin
    wr_en   = 1'b0;
    wr_word = '0;
    for (int l = 0; l < LANES; l++) begin
      if (serve[l] && we_vec[l]) begin
        wr_en   = 1'b1;
        wr_word = wdata_vec[l*WORD_W +: WORD_W];
      end
    end
  end

  assign row = ROW_W'(spm_pkg::row_of(32'(lead_addr), BANKS));

endmodule

// File: rtl/spm_bank_store.sv
// One single-ported bank: asynchronous read of the selected row, write on the clock.
module spm_bank_store #(
  parameter int unsigned ROW_W  = 6,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned ROWS  = 1 << ROW_W
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ROW_W-1:0]  row,
  input  logic [WORD_W-1:0] wr_word,
  output logic [WORD_W-1:0] rd_word
);

  logic [WORD_W-1:0] cells [ROWS];

  always_ff @(posedge clk) begin
    if (wr_en) cells[row] <= wr_word;
  end

  assign rd_word = cells[row];

endmodule

// File: rtl/lane_bank_mem.sv
module lane_bank_mem #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned BANKS  = 16,
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned WORD_W = 32
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [LANES-1:0]        lane_valid,
  input  logic [LANES-1:0]        lane_we,
  input  logic [LANES*ADDR_W-1:0] lane_addr,
  input  logic [LANES*WORD_W-1:0] lane_wdata,
  output logic [LANES*WORD_W-1:0] rd_data,
  output logic                    done
);

  localparam int unsigned BANK_W = $clog2(BANKS);
  localparam int unsigned ROW_W  = ADDR_W - BANK_W;

  spm_pkg::spm_state_e state_q;

  logic [LANES-1:0]        pend_q;
  logic [LANES-1:0]        we_q;
  logic [LANES*ADDR_W-1:0] addr_q;
  logic [LANES*WORD_W-1:0] wdata_q;
  logic                    done_q;
  logic [WORD_W-1:0]       rd_q [LANES];

  // Named internal events, also observed by the checker.
  logic                    busy_w;
  logic                    accept_w;
  logic [LANES-1:0]        served_w;
  logic [LANES-1:0]        pend_next_w;
  logic                    last_w;

  logic [LANES-1:0]        serve_bank [BANKS];
  logic [WORD_W-1:0]       bank_word  [BANKS];

  assign busy_w    = (state_q == spm_pkg::ST_SERVE);
  assign req_ready = !busy_w;
  assign accept_w  = req_valid && req_ready;

  for (genvar b = 0; b < BANKS; b++) begin : g_bank
    logic [ROW_W-1:0]  row;
    logic              wr_en;
    logic [WORD_W-1:0] wr_word;

    spm_bank_pick #(
      .LANES(LANES), .BANKS(BANKS), .ADDR_W(ADDR_W),
      .WORD_W(WORD_W), .BANK_ID(b)
    ) u_pick (
      .pending  (pend_q),
      .addr_vec (addr_q),
      .we_vec   (we_q),
      .wdata_vec(wdata_q),
      .serve    (serve_bank[b]),
      .row      (row),
      .wr_en    (wr_en),
      .wr_word  (wr_word)
    );

    spm_bank_store #(
      .ROW_W(ROW_W), .WORD_W(WORD_W)
    ) u_store (
      .clk    (clk),
      .wr_en  (wr_en && busy_w),
      .row    (row),
      .wr_word(wr_word),
      .rd_word(bank_word[b])
    );
  end

  always_comb begin
    served_w = '0;
    for (int b = 0; b < BANKS; b++) served_w = served_w | serve_bank[b];
  end

  assign pend_next_w = pend_q & ~served_w;
  assign last_w      = busy_w && (pend_next_w == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= spm_pkg::ST_IDLE;
      pend_q  <= '0;
      we_q    <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_w;
      case (state_q)
        spm_pkg::ST_IDLE: begin
          if (accept_w) begin
            pend_q  <= lane_valid;
            we_q    <= lane_we;
            addr_q  <= lane_addr;
            wdata_q <= lane_wdata;
            state_q <= spm_pkg::ST_SERVE;
          end
        end
        default: begin
          pend_q <= pend_next_w;
          if (pend_next_w == '0) state_q <= spm_pkg::ST_IDLE;
        end
      endcase
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [BANK_W-1:0] lane_bank;
    assign lane_bank =
      BANK_W'(spm_pkg::bank_of(32'(addr_q[l*ADDR_W +: ADDR_W]), BANKS));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 rd_q[l] <= '0;
      else if (busy_w && served_w[l] && !we_q[l]) rd_q[l] <= bank_word[lane_bank];
    end

    assign rd_data[l*WORD_W +: WORD_W] = rd_q[l];
  end

  assign done = done_q;

endmodule

// File: rtl/spm_checker.sv
module spm_checker #(
  parameter int unsigned LANES  = 16,
  parameter int unsigned WORD_W = 32,
  localparam int unsigned CNT_W = $clog2(LANES + 1) + 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    req_valid,
  input logic                    req_ready,
  input logic                    done,
  input logic                    busy,
  input logic [LANES-1:0]        pend,
  input logic [LANES-1:0]        served,
  input logic [LANES*WORD_W-1:0] rd_data
);

  logic [CNT_W-1:0] busy_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  p_accept_drops_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_with_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  p_idle_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (pend == '0));

  p_progress_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (pend != '0)) |-> (served != '0));

  p_latency_cap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_cnt < CNT_W'(LANES)));

  p_rd_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(rd_data));

endmodule

bind lane_bank_mem spm_checker #(.LANES(LANES), .WORD_W(WORD_W)) u_spm_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .done     (done),
  .busy     (busy_w),
  .pend     (pend_q),
  .served   (served_w),
  .rd_data  (rd_data)
);

// File: tb/test_lane_bank_mem.sv
module test_lane_bank_mem;

  localparam int LANES = 16;
  localparam int AW    = 10;
  localparam int DW    = 32;
  localparam int WORDS = 1 << AW;

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 req_valid = 1'b0;
  logic                 req_ready;
  logic [LANES-1:0]     lane_valid = '0;
  logic [LANES-1:0]     lane_we = '0;
  logic [LANES*AW-1:0]  lane_addr = '0;
  logic [LANES*DW-1:0]  lane_wdata = '0;
  logic [LANES*DW-1:0]  rd_data;
  logic                 done;

  always #5 clk = ~clk;

  lane_bank_mem i_lane_bank_mem (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .lane_valid(lane_valid), .lane_we(lane_we), .lane_addr(lane_addr),
    .lane_wdata(lane_wdata), .rd_data(rd_data), .done(done)
  );

  int checks = 0;
  int fails  = 0;

  logic [DW-1:0]    model   [WORDS];
  logic [DW-1:0]    prev_rd [LANES];
  logic [LANES-1:0] t_v, t_we;
  logic [AW-1:0]    t_addr  [LANES];
  logic [DW-1:0]    t_data  [LANES];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] lane_rd(input int l);
    return rd_data[l*DW +: DW];
  endfunction

  // Largest count of distinct words per bank (bank = low 4 address bits).
  function automatic int exp_cycles();
    int cnt [16];
    int worst;
    bit seen;
    worst = 1;
    for (int b = 0; b < 16; b++) cnt[b] = 0;
    for (int l = 0; l < LANES; l++) begin
      if (t_v[l]) begin
        seen = 1'b0;
        for (int j = 0; j < l; j++)
          if (t_v[j] && t_addr[j] == t_addr[l]) seen = 1'b1;
        if (!seen) cnt[t_addr[l][3:0]]++;
      end
    end
    for (int b = 0; b < 16; b++) if (cnt[b] > worst) worst = cnt[b];
    return worst;
  endfunction

  task automatic apply(input string what, input string lat_req);
    logic [DW-1:0] exp_rd [LANES];
    int k_exp;
    int n;
    k_exp = exp_cycles();
    for (int l = 0; l < LANES; l++)
      exp_rd[l] = (t_v[l] && !t_we[l]) ? model[t_addr[l]] : prev_rd[l];
    for (int l = 0; l < LANES; l++)
      if (t_v[l] && t_we[l]) model[t_addr[l]] = t_data[l];

    @(negedge clk);
    for (int l = 0; l < LANES; l++) begin
      lane_addr[l*AW +: AW]  = t_addr[l];
      lane_wdata[l*DW +: DW] = t_data[l];
    end
    lane_valid = t_v;
    lane_we    = t_we;
    req_valid  = 1'b1;
    chk(req_ready == 1'b1, "R2", {what, " ready before request"}, 32'(req_ready), 1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    n = 0;
    while (!done && n < 40) begin
      n++;
      if (req_ready) chk(1'b0, "R2", {what, " ready high while serving"}, 1, 0);
      @(negedge clk);
    end
    chk(n == k_exp, lat_req, {what, " cycles to done"}, 32'(n), 32'(k_exp));
    for (int l = 0; l < LANES; l++) begin
      chk(lane_rd(l) === exp_rd[l],
          (t_v[l] && !t_we[l]) ? "R5" : "R7",
          $sformatf("%s lane %0d data", what, l), lane_rd(l), exp_rd[l]);
      prev_rd[l] = exp_rd[l];
    end
    @(negedge clk);
    chk(done == 1'b0, "R2", {what, " done lasts one cycle"}, 32'(done), 0);
  endtask

  task automatic clear_req();
    t_v = '0;
    t_we = '0;
    for (int l = 0; l < LANES; l++) begin
      t_addr[l] = '0;
      t_data[l] = '0;
    end
  endtask

  task automatic stride_read(input int base, input int s, input string req);
    clear_req();
    t_v = '1;
    for (int l = 0; l < LANES; l++) t_addr[l] = AW'(base + s * l);
    apply($sformatf("stride %0d read", s), req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int l = 0; l < LANES; l++) prev_rd[l] = '0;
    repeat (3) @(negedge clk);
    // R9: reset values observed during reset and after release.
    chk(req_ready == 1'b1, "R9", "ready in reset", 32'(req_ready), 1);
    chk(done == 1'b0, "R9", "done in reset", 32'(done), 0);
    chk(rd_data == '0, "R9", "rd_data in reset", rd_data[31:0], 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1 && done == 1'b0, "R9", "idle after reset", 32'(req_ready), 1);

    // R1: fill memory with stride-1 writes, conflict-free.
    for (int blk = 0; blk < WORDS / LANES; blk++) begin
      clear_req();
      t_v = '1;
      t_we = '1;
      for (int l = 0; l < LANES; l++) begin
        t_addr[l] = AW'(blk * LANES + l);
        t_data[l] = 32'hA500_0000 ^ (32'(blk * LANES + l) * 32'h0001_0193);
      end
      apply("fill", "R1");
    end

    // R1/R3: bank mapping through strides.
    stride_read(0, 1, "R1");
    stride_read(5, 3, "R3");
    stride_read(2, 2, "R3");
    stride_read(1, 8, "R3");
    stride_read(7, 16, "R3");
    stride_read(9, 7, "R3");

    // R1: two words in bank 3 conflict; bank 3 and bank 4 do not.
    clear_req(); t_v = 16'h0003; t_addr[0] = 10'h003; t_addr[1] = 10'h013;
    apply("same bank pair", "R1");
    clear_req(); t_v = 16'h0003; t_addr[0] = 10'h003; t_addr[1] = 10'h004;
    apply("adjacent bank pair", "R1");

    // R4: broadcast of one address to all lanes.
    clear_req(); t_v = '1;
    for (int l = 0; l < LANES; l++) t_addr[l] = 10'h155;
    apply("broadcast all", "R4");
    // R4: broadcast group mixed with a second word in the same bank.
    clear_req(); t_v = '1;
    for (int l = 0; l < LANES; l++) t_addr[l] = l[0] ? 10'h0A6 : 10'h1F6;
    apply("two groups one bank", "R4");

    // R6: every lane writes one address; highest lane wins.
    clear_req(); t_v = '1; t_we = '1;
    for (int l = 0; l < LANES; l++) begin
      t_addr[l] = 10'h05A;
      t_data[l] = 32'hC0DE_0000 + 32'(l);
    end
    apply("all lanes write one word", "R6");
    clear_req(); t_v = 16'h0001; t_addr[0] = 10'h05A;
    apply("readback winner", "R6");

    // R5: read and write of one word in a single request return old data.
    clear_req(); t_v = 16'h0003; t_we = 16'h0002;
    t_addr[0] = 10'h077; t_addr[1] = 10'h077; t_data[1] = 32'h1234_5678;
    apply("read beside write", "R5");
    clear_req(); t_v = 16'h0004; t_addr[2] = 10'h077;
    apply("readback new word", "R5");

    // R7: invalid lanes with write enable set change nothing.
    clear_req(); t_v = 16'h0001; t_we = '1;
    for (int l = 0; l < LANES; l++) begin
      t_addr[l] = AW'(10'h200 + l);
      t_data[l] = 32'hDEAD_0000 + 32'(l);
    end
    apply("single valid writer", "R7");
    clear_req(); t_v = 16'hFFFE;
    for (int l = 0; l < LANES; l++) t_addr[l] = AW'(10'h200 + l);
    apply("readback untouched words", "R7");

    // R2: empty request still completes with one serving cycle.
    clear_req();
    apply("empty request", "R2");

    // R8: read data holds during idle cycles.
    repeat (5) @(negedge clk);
    for (int l = 0; l < LANES; l++)
      chk(lane_rd(l) === prev_rd[l], "R8", $sformatf("idle hold lane %0d", l),
          lane_rd(l), prev_rd[l]);

    // Random mix over a small pool to produce conflicts and broadcasts.
    for (int it = 0; it < 400; it++) begin
      clear_req();
      t_v  = 16'($urandom);
      t_we = 16'($urandom) & 16'($urandom);
      for (int l = 0; l < LANES; l++) begin
        t_addr[l] = AW'($urandom_range(0, 47));
        t_data[l] = $urandom;
      end
      apply($sformatf("random %0d", it), "R3");
    end

    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule